// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block joins two 8-bit bidirectional buses, called A and B. Each direction of transfer has its own capture register, and each register is loaded on the rising edge of its own clock. One register captures what is on the A bus and serves traffic towards B. The other captures the B bus and serves traffic towards A. For each direction, a source-select input chooses what the driving side puts out: either the live value on the opposite bus or the value held in that direction's register. The data is never inverted.

An active-low output enable and a direction input decide which bus the block drives, if either. With the enable high, both sides are isolated. Both registers can still be loaded in that state, separately or on the same edge, so the block can hold data while it drives nothing.

The pads are modelled with explicit signals: an input, an output value and an output enable for each bus. When the block drives a bus, the value that bus carries is the block's own output, and a register that samples that bus captures that output. Each capture register has an asynchronous reset. The reset is released synchronously in that register's own clock domain.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, both capture registers hold zero, including across edges of their clocks. With a stored source selected, each output shows 8'h00.
- R2: A rising edge of `clk_ab` loads the A-bus value into the A-to-B register. A rising edge of `clk_ba` loads the B-bus value into the B-to-A register. The bus value is `a_i` or `b_i` when that bus is not driven by the block.
- R3: With `oe_n` = 1, `a_oe` and `b_oe` are both 0, whatever `dir` is.
- R4: With `oe_n` = 0, `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0 (transfer from A to B). `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0. The two enables are never 1 together.
- R5: `b_o` equals `a_i` bit for bit when `sel_ab` = 0 (live). It equals the A-to-B register when `sel_ab` = 1 (stored).
- R6: `a_o` equals `b_i` bit for bit when `sel_ba` = 0. It equals the B-to-A register when `sel_ba` = 1.
- R7: Capture works in every enable and direction setting, including isolation. Pulsing both clocks on the same edge loads both registers, each from the values present before that edge.
- R8: When the block drives a bus, a capture from that bus loads the block's own output value (`a_o` for the A bus, `b_o` for the B bus). It does not load the pad input.
- R9: After `rst_n` rises, each register stays at zero through the first two rising edges of its own clock. It captures normally from the third edge onwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of both capture registers |
| clk_ab | input | 1 | Capture clock of the A-to-B register (rising edge) |
| clk_ba | input | 1 | Capture clock of the B-to-A register (rising edge) |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_ab | input | 1 | Source for B output: 0 live A, 1 stored register |
| sel_ba | input | 1 | Source for A output: 0 live B, 1 stored register |
| a_i | input | 8 | Value seen on the A-bus pads |
| a_o | output | 8 | Value offered to the A-bus pads |
| a_oe | output | 1 | A-bus pad drive enable |
| b_i | input | 8 | Value seen on the B-bus pads |
| b_o | output | 8 | Value offered to the B-bus pads |
| b_oe | output | 1 | B-bus pad drive enable |

## Verification
The assertions check the combinational rules on every evaluation: isolation, the rule that only one bus is driven, and the match of each output with its live or stored source. The bench alone can show what the registers hold. That covers zero during reset, the two ignored edges after release, capture during isolation, simultaneous loading from pre-edge values, and the capture of the block's own driven value. The bench sweeps all sixteen combinations of enable, direction and the two source selects under several data patterns and clock pulse choices, and compares against a model of the bus values that it keeps itself.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Source of a driving side: pass the opposite bus through, or the held word.
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  // Transfer directions; index of the per-direction arrays in the top.
  localparam int unsigned PATH_AB = 0;
  localparam int unsigned PATH_BA = 1;
  localparam int unsigned NUM_PATHS = 2;

  typedef struct packed {
    logic drive_a;
    logic drive_b;
  } drive_t;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST:0], 1'b1};
    chain_d = chain_d[LAST:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[LAST];

endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import xcvr_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output drive_t drv
);

  always_comb begin
    drv         = '0;
    if (!oe_n) begin
      drv.drive_b = dir;
      drv.drive_a = !dir;
    end
  end

  always_comb begin
    AST_ISOLATE_BOTH: assert (!oe_n || (!drv.drive_a && !drv.drive_b)) // R3
      else $error("isolation violated");
    AST_SINGLE_DRIVER: assert (!(drv.drive_a && drv.drive_b)) // R4
      else $error("both buses driven");
    AST_ENABLED_DRIVES: assert (oe_n || (drv.drive_a != drv.drive_b)) // R4
      else $error("enabled but no bus driven");
  end

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  src_sel_e         sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out
);

  always_comb begin
    unique case (sel)
      SRC_STORED: out = stored;
      default:    out = live;
    endcase
  end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe
);

  drive_t drv;

  logic     [NUM_PATHS-1:0]            path_clk;
  logic     [NUM_PATHS-1:0]            path_rst_n;
  src_sel_e                            path_sel [NUM_PATHS];
  logic     [NUM_PATHS-1:0][WIDTH-1:0] path_live;
  logic     [NUM_PATHS-1:0][WIDTH-1:0] path_cap_d;
  logic     [NUM_PATHS-1:0][WIDTH-1:0] path_held;
  logic     [NUM_PATHS-1:0][WIDTH-1:0] path_out;

  xcvr_drive_ctl u_drive_ctl (
    .oe_n (oe_n),
    .dir  (dir),
    .drv  (drv)
  );

  assign a_oe = drv.drive_a;
  assign b_oe = drv.drive_b;

  // Per-direction wiring: A-to-B samples the A bus and feeds B, and vice versa.
  assign path_clk[PATH_AB]   = clk_ab;
  assign path_clk[PATH_BA]   = clk_ba;
  assign path_sel[PATH_AB]   = src_sel_e'(sel_ab);
  assign path_sel[PATH_BA]   = src_sel_e'(sel_ba);
  assign path_live[PATH_AB]  = a_i;
  assign path_live[PATH_BA]  = b_i;

  // The bus a register samples carries the block's own output when driven.
  assign path_cap_d[PATH_AB] = drv.drive_a ? path_out[PATH_BA] : a_i;
  assign path_cap_d[PATH_BA] = drv.drive_b ? path_out[PATH_AB] : b_i;

  for (genvar gp = 0; gp < NUM_PATHS; gp++) begin : g_path
    xcvr_rst_sync #(
      .STAGES (SYNC_DEPTH)
    ) u_rst_sync (
      .clk        (path_clk[gp]),
      .rst_n      (rst_n),
      .rst_n_sync (path_rst_n[gp])
    );

    xcvr_cap_reg #(
      .WIDTH (WIDTH)
    ) u_cap_reg (
      .clk     (path_clk[gp]),
      .rst_n   (path_rst_n[gp]),
      .load_en (1'b1),
      .d       (path_cap_d[gp]),
      .q       (path_held[gp])
    );

    xcvr_path_mux #(
      .WIDTH (WIDTH)
    ) u_path_mux (
      .sel    (path_sel[gp]),
      .live   (path_live[gp]),
      .stored (path_held[gp]),
      .out    (path_out[gp])
    );
  end

  assign b_o = path_out[PATH_AB];
  assign a_o = path_out[PATH_BA];

  always_comb begin
    AST_B_FOLLOWS_A: assert (sel_ab || (b_o == a_i)) // R5
      else $error("live B output differs from A input");
    AST_A_FOLLOWS_B: assert (sel_ba || (a_o == b_i)) // R6
      else $error("live A output differs from B input");
    AST_B_SHOWS_HELD: assert (!sel_ab || (b_o == path_held[PATH_AB])) // R5
      else $error("stored B output differs from register");
    AST_A_SHOWS_HELD: assert (!sel_ba || (a_o == path_held[PATH_BA])) // R6
      else $error("stored A output differs from register");
    AST_RESET_CLEARS: assert (rst_n || (path_held == '0)) // R1
      else $error("register not cleared in reset");
  end

endmodule

// File: tb/test_regbus_xcvr.sv
module test_regbus_xcvr;

  localparam int W = 8;

  logic         clk;
  logic         rst_n, clk_ab, clk_ba, oe_n, dir, sel_ab, sel_ba;
  logic [W-1:0] a_i, b_i, a_o, b_o;
  logic         a_oe, b_oe;

  int checks   = 0;
  int failures = 0;
  logic [W-1:0] m_ab, m_ba;

  regbus_xcvr i_regbus_xcvr (
    .rst_n (rst_n), .clk_ab (clk_ab), .clk_ba (clk_ba),
    .oe_n (oe_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
    .a_i (a_i), .a_o (a_o), .a_oe (a_oe),
    .b_i (b_i), .b_o (b_o), .b_oe (b_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic on, input logic d, input logic sab, input logic sba,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    oe_n = on; dir = d; sel_ab = sab; sel_ba = sba; a_i = a; b_i = b;
    #2;
  endtask

  function automatic logic exp_aoe(); return !oe_n && !dir; endfunction
  function automatic logic exp_boe(); return !oe_n && dir;  endfunction
  function automatic logic [W-1:0] exp_bo(); return sel_ab ? m_ab : a_i; endfunction
  function automatic logic [W-1:0] exp_ao(); return sel_ba ? m_ba : b_i; endfunction

  task automatic check_outs();
    string et;
    et = oe_n ? "R3 enables" : "R4 enables";
    chk(et, {6'd0, a_oe, b_oe}, {6'd0, exp_aoe(), exp_boe()});
    chk(sel_ab ? "R5 stored b_o" : "R5 live b_o", b_o, exp_bo());
    chk(sel_ba ? "R6 stored a_o" : "R6 live a_o", a_o, exp_ao());
  endtask

  // Pulse the selected clocks together; update the model when load is live.
  task automatic pulse(input logic p_ab, input logic p_ba, input logic upd);
    logic [W-1:0] na, nb;
    na = exp_aoe() ? exp_ao() : a_i;
    nb = exp_boe() ? exp_bo() : b_i;
    {clk_ab, clk_ba} = {p_ab, p_ba};
    #3;
    {clk_ab, clk_ba} = 2'b00;
    #3;
    if (upd && p_ab) m_ab = na;
    if (upd && p_ba) m_ba = nb;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    string tg;
    rst_n = 1'b0; clk_ab = 1'b0; clk_ba = 1'b0;
    m_ab = '0; m_ba = '0;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h3C);
    // R1: registers read zero in reset, even across clock edges
    chk("R1 reset b_o", b_o, 8'h00);
    chk("R1 reset a_o", a_o, 8'h00);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R1 reset edge b_o", b_o, 8'h00);
    chk("R1 reset edge a_o", a_o, 8'h00);
    // R9: two edges after release are ignored
    #5 rst_n = 1'b1; #5;
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hC3);
    pulse(1'b1, 1'b1, 1'b0);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R9 held after release b_o", b_o, 8'h00);
    chk("R9 held after release a_o", a_o, 8'h00);
    pulse(1'b1, 1'b1, 1'b1);
    chk("R2 first capture b_o", b_o, 8'h5A);
    chk("R2 first capture a_o", a_o, 8'hC3);

    // Sweep every control combination with several data and pulse choices.
    for (int ctl = 0; ctl < 16; ctl++) begin
      for (int p = 0; p < 4; p++) begin
        drive(ctl[3], ctl[2], ctl[1], ctl[0],
              W'((ctl * 29 + p * 71 + 13) & 8'hFF),
              W'((ctl * 53 + p * 97 + 200) & 8'hFF));
        check_outs();
        if (ctl[3]) tg = "R7 isolated capture";
        else if ((ctl[2] && p[1]) || (!ctl[2] && p[0])) tg = "R8 driven-bus capture";
        else tg = "R2 capture";
        if (p == 3) tg = {tg, " R7 both"};
        pulse(p[0], p[1], 1'b1);
        // Force stored view to read the registers back
        sel_ab = 1'b1; sel_ba = 1'b1; #2;
        chk({tg, " ab reg"}, b_o, m_ab);
        chk({tg, " ba reg"}, a_o, m_ba);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule